// File: doc/BRIEF.md
# I2C Target Front End with Fixed Command Pointer

This block is the serial-bus target that sits in front of a small register bank of an 8-bit port expander. It runs from a fast system clock and oversamples the open-drain SCL and SDA lines. Each line passes through a two-flop synchronizer and a majority-vote window. From the filtered lines the block finds Start, repeated Start and Stop conditions. It compares the 7-bit address against a fixed 4-bit prefix joined to three strap inputs, and it acknowledges the bytes it accepts by pulling SDA low.

In a write transfer the first byte after the address is a command. Its two low bits become the register pointer. Every later byte is handed to the bank as a one-cycle write beat, tagged with that pointer. In a read transfer the block takes one byte from the bank for each slot it transmits and shifts the byte out MSB first. It keeps doing so for as long as the master acknowledges. The pointer never advances. Repeated bytes, and reads after a repeated Start, all go to the same register until a new command byte arrives.

Both streams toward the bank run at bus speed and cannot be throttled, because the block never stretches the clock. The write stream is valid-only: `wr_valid` has no ready partner, so the bank must accept every beat on the cycle it is presented. The read stream is pulled: the bank keeps `rd_data` valid for the current `reg_sel`, and the block samples it in the cycle `rd_strobe` is high.

Top module: `i2c_cmd_target`

## Requirements
- R1: The target answers only to the 7-bit address whose upper four bits are 0011 and whose lower three bits equal `strap[2:0]`, so that 0x18 to 0x1F are reachable. It acknowledges a matching address byte by driving `sda_oe` high through the ninth clock.
- R2: Bit 0 of the address byte gives the direction. A 1 starts a read, in which the target loads a byte (`rd_strobe`) at the end of the address acknowledge. A 0 starts a write, in which the next byte is the command.
- R3: A falling SDA while SCL is high is a Start, and a rising SDA while SCL is high is a Stop. Each Stop produces exactly one `stop_pulse` cycle and returns the target to idle with SDA released.
- R4: The target acknowledges every byte it receives in a matched write transfer, both the command byte and every data byte.
- R5: Only bits [1:0] of the command byte set `reg_sel`, with 0 for input, 1 for output, 2 for polarity and 3 for direction. The upper six bits are ignored.
- R6: `reg_sel` holds across all data bytes of a transfer, across a repeated Start, and across later transfers, until another command byte is received.
- R7: Each data byte written after the command produces one `wr_valid` cycle with the byte on `wr_data` and its target on `reg_sel`. The number of bytes per transfer is unlimited.
- R8: In a read, the target shifts out `rd_data` MSB first and loads a new byte with one `rd_strobe` cycle after each master ACK. The number of bytes is unlimited.
- R9: After the master NACKs a read byte, the target keeps SDA released and sends no further data until the next Start.
- R10: After an address byte that does not match, the target gives no ACK, produces no write beat and keeps `reg_sel`. It ignores all traffic until the next Start or Stop, and it responds normally again after a repeated Start that carries a matching address.
- R11: While `rst_n` is low, the target goes idle, releases SDA and sets `reg_sel` to 0. A reset in the middle of a transfer abandons that transfer.
- R12: The majority window is FILT_WIN=3 samples wide, so a spike of one system clock on SDA while SCL is high is neither taken as a Start or Stop nor as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Active-low reset, asynchronous to bus |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| strap | input | 3 | Low three address bits |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_sel | output | 2 | Current register pointer |
| wr_valid | output | 1 | One-cycle write beat toward the bank |
| wr_data | output | 8 | Byte of the write beat |
| rd_data | input | 8 | Contents of the selected register |
| rd_strobe | output | 1 | Cycle in which `rd_data` is captured |
| stop_pulse | output | 1 | One cycle per Stop condition |

## Verification
A bus edge reaches the engine registers no later than six system clocks after it is driven: two synchronizer stages, two window samples to win the vote, the filter output register, and the engine flop. `sda_oe`, `reg_sel`, `wr_valid` and `rd_strobe` therefore settle within six clocks of the SCL fall that ends a byte or an acknowledge. The bench holds every SCL phase for eight clocks and samples only at the end of a phase, on a falling clock edge, so every result is already due and stable. Strobe counts are gathered by a monitor and compared only after the transaction has closed.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK,
    S_WDAT, S_WACK, S_TX, S_MACK, S_SKIP
  } eng_st_t;
endpackage

// File: rtl/i2ct_filt.sv
module i2ct_filt #(
  parameter int WIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] HALF = CW'(WIN / 2);

  logic [1:0]     sync;
  logic [WIN-1:0] win;
  logic [CW-1:0]  ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < WIN; i++) ones = ones + CW'(win[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      win  <= '1;
      dout <= 1'b1;
    end else begin
      sync <= {sync[0], din};
      win  <= {win[WIN-2:0], sync[1]};
      dout <= (ones > HALF);
    end
  end
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  =  scl_f & ~scl_q;
  assign scl_fall  = ~scl_f &  scl_q;
  assign start_det =  scl_f &  scl_q &  sda_q & ~sda_f;
  assign stop_det  =  scl_f &  scl_q & ~sda_q &  sda_f;
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          STRAP_W  = 3,
  parameter int          SEL_W    = 2,
  parameter logic [3:0]  ADDR_PFX = 4'b0011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_f,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DW-1:0]      rd_data,
  output logic               sda_oe,
  output logic [SEL_W-1:0]   reg_sel,
  output logic               wr_valid,
  output logic [DW-1:0]      wr_data,
  output logic               rd_strobe,
  output logic               stop_pulse,
  output eng_st_t            st_o
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW);

  eng_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    sh;
  logic             rw;
  logic             macked;

  assign st_o = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      sh         <= '0;
      rw         <= 1'b0;
      macked     <= 1'b0;
      sda_oe     <= 1'b0;
      reg_sel    <= '0;
      wr_valid   <= 1'b0;
      wr_data    <= '0;
      rd_strobe  <= 1'b0;
      stop_pulse <= 1'b0;
    end else begin
      wr_valid   <= 1'b0;
      rd_strobe  <= 1'b0;
      stop_pulse <= 1'b0;
      if (stop_det) begin
        st         <= S_IDLE;
        sda_oe     <= 1'b0;
        stop_pulse <= 1'b1;
      end else if (start_det) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        macked <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sh[DW-1:1] == {ADDR_PFX, strap}) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  st     <= S_AACK;
                end else begin
                  st <= S_SKIP;
                end
              end else if (st == S_CMD) begin
                reg_sel <= sh[SEL_W-1:0];
                sda_oe  <= 1'b1;
                st      <= S_CACK;
              end else begin
                wr_valid <= 1'b1;
                wr_data  <= sh;
                sda_oe   <= 1'b1;
                st       <= S_WACK;
              end
            end
          end
          S_AACK, S_CACK, S_WACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (st == S_AACK && rw) begin
                sh        <= rd_data;
                sda_oe    <= ~rd_data[DW-1];
                rd_strobe <= 1'b1;
                st        <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= (st == S_AACK) ? S_CMD : S_WDAT;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
                st     <= S_MACK;
              end else begin
                sh     <= sh << 1;
                sda_oe <= ~sh[DW-2];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              macked <= ~sda_f;
            end else if (scl_fall) begin
              if (macked) begin
                sh        <= rd_data;
                sda_oe    <= ~rd_data[DW-1];
                rd_strobe <= 1'b1;
                st        <= S_TX;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
  import i2ct_pkg::*;
#(
  parameter int         DW       = 8,
  parameter int         STRAP_W  = 3,
  parameter int         SEL_W    = 2,
  parameter int         FILT_WIN = 3,
  parameter logic [3:0] ADDR_PFX = 4'b0011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap,
  output logic               sda_oe,
  output logic [SEL_W-1:0]   reg_sel,
  output logic               wr_valid,
  output logic [DW-1:0]      wr_data,
  input  logic [DW-1:0]      rd_data,
  output logic               rd_strobe,
  output logic               stop_pulse
);
  logic [1:0] raw, flt;
  logic       scl_flt, sda_flt;
  logic       scl_rise, scl_fall, start_det, stop_det;
  eng_st_t    eng_st;

  assign raw = {sda_i, scl_i};

  for (genvar gi = 0; gi < 2; gi++) begin : g_line
    i2ct_filt #(.WIN(FILT_WIN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[gi]),
      .dout (flt[gi])
    );
  end

  assign scl_flt = flt[0];
  assign sda_flt = flt[1];

  i2ct_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_flt),
    .sda_f    (sda_flt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2ct_engine #(
    .DW(DW), .STRAP_W(STRAP_W), .SEL_W(SEL_W), .ADDR_PFX(ADDR_PFX)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_f     (sda_flt),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap     (strap),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .reg_sel   (reg_sel),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .rd_strobe (rd_strobe),
    .stop_pulse(stop_pulse),
    .st_o      (eng_st)
  );
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk
  import i2ct_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_f,
  input logic             sda_oe,
  input logic             wr_valid,
  input logic             rd_strobe,
  input logic             stop_pulse,
  input logic [SEL_W-1:0] reg_sel,
  input eng_st_t          st
);
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R7

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe); // R8

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> !sda_oe); // R3

  AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !stop_pulse); // R3

  AST_SEL_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_sel) |-> $past(st) == S_CMD); // R6

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_f || !sda_oe)); // R4

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> (!sda_oe && !wr_valid && !rd_strobe)); // R10
endmodule

bind i2c_cmd_target i2ct_chk #(.SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_f     (scl_flt),
  .sda_oe    (sda_oe),
  .wr_valid  (wr_valid),
  .rd_strobe (rd_strobe),
  .stop_pulse(stop_pulse),
  .reg_sel   (reg_sel),
  .st        (eng_st)
);

// File: tb/sim_i2c_cmd_target.sv
`timescale 1ns/1ps
module sim_i2c_cmd_target;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       sda_oe, wr_valid, rd_strobe, stop_pulse;
  logic [1:0] reg_sel;
  logic [7:0] wr_data, rd_data;
  logic       sda_line;
  logic [7:0] model [4];

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, stop_cnt = 0;
  logic [7:0] last_wd = 8'h00;
  logic [1:0] last_ws = 2'd0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = model[reg_sel];

  i2c_cmd_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap(strap), .sda_oe(sda_oe), .reg_sel(reg_sel),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_data(rd_data),
    .rd_strobe(rd_strobe), .stop_pulse(stop_pulse)
  );

  always @(posedge clk) begin
    if (wr_valid) begin wr_cnt++; last_wd = wr_data; last_ws = reg_sel; end
    if (rd_strobe) rd_cnt++;
    if (stop_pulse) stop_cnt++;
  end

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(Q);
    scl_m = 1'b1; waitq(2*Q);
    sda_m = 1'b0; waitq(2*Q);
    scl_m = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq(Q);
    scl_m = 1'b1; waitq(2*Q);
    sda_m = 1'b1; waitq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitq(Q);
      scl_m = 1'b1; waitq(Q);
      if (glitch && i == 3) begin
        sda_m = ~sda_m; waitq(1);
        sda_m = ~sda_m; waitq(Q-1);
      end else begin
        waitq(Q);
      end
      scl_m = 1'b0; waitq(Q);
    end
    sda_m = 1'b1; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    acked = ~sda_line; waitq(Q);
    scl_m = 1'b0; waitq(Q);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq(Q);
      scl_m = 1'b1; waitq(Q);
      b[i] = sda_line; waitq(Q);
      scl_m = 1'b0; waitq(Q);
    end
    sda_m = ack ? 1'b0 : 1'b1; waitq(Q);
    scl_m = 1'b1; waitq(2*Q);
    scl_m = 1'b0; waitq(Q);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] rb;
    logic [6:0] own;
    int w0, r0, s0;
    model[0] = 8'hA5; model[1] = 8'h00; model[2] = 8'hF0; model[3] = 8'hFF;
    waitq(4);
    // R11: state during reset
    chk("R11 reset sda_oe", {31'd0, sda_oe}, 0);
    chk("R11 reset reg_sel", {30'd0, reg_sel}, 0);
    chk("R11 reset wr_valid", {31'd0, wr_valid}, 0);
    rst_n = 1'b1; waitq(10);

    // R1 R3: address sweep over all straps
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 10; a++) begin
        logic [6:0] ad;
        ad = (a < 8) ? 7'(7'h18 + a) : (a == 8 ? 7'(7'h38 + s) : 7'(7'h08 + s));
        s0 = stop_cnt;
        bus_start();
        send_byte({ad, 1'b0}, 1'b0, ak);
        chk("R1 address ack", {31'd0, ak}, {31'd0, ad == (7'h18 + 7'(s))});
        bus_stop(); waitq(Q);
        if (a == 0) chk("R3 one stop pulse", stop_cnt - s0, 1);
      end
    end
    chk("R3 released after stop", {31'd0, sda_oe}, 0);

    strap = 3'd5;
    own = 7'h1D;
    // R4 R5 R6 R7 R2 R8 R9: command sweep with writes and reads
    for (int c = 0; c < 8; c++) begin
      logic [7:0] cmd;
      logic [1:0] sel;
      cmd = 8'(8'h5C + c);
      sel = cmd[1:0];
      w0 = wr_cnt;
      bus_start();
      send_byte({own, 1'b0}, 1'b0, ak);
      send_byte(cmd, 1'b0, ak);
      chk("R4 command ack", {31'd0, ak}, 1);
      chk("R5 pointer from low bits", {30'd0, reg_sel}, {30'd0, sel});
      for (int k = 0; k < 3; k++) begin
        logic [7:0] d;
        d = 8'(c * 37 + k * 11 + 3);
        send_byte(d, 1'b0, ak);
        chk("R4 data ack", {31'd0, ak}, 1);
        chk("R7 write data", {24'd0, last_wd}, {24'd0, d});
        chk("R6 pointer held on writes", {30'd0, last_ws}, {30'd0, sel});
        if (sel != 2'd0) model[sel] = d;
      end
      bus_stop();
      chk("R7 one beat per byte", wr_cnt - w0, 3);

      r0 = rd_cnt;
      bus_start();
      send_byte({own, 1'b0}, 1'b0, ak);
      send_byte(cmd, 1'b0, ak);
      bus_start();
      send_byte({own, 1'b1}, 1'b0, ak);
      chk("R2 read ack", {31'd0, ak}, 1);
      chk("R2 read loads byte", rd_cnt - r0, 1);
      for (int k = 0; k < 3; k++) begin
        recv_byte(k < 2, rb);
        chk("R8 read data after repeated start", {24'd0, rb}, {24'd0, model[sel]});
      end
      chk("R8 one strobe per byte", rd_cnt - r0, 3);
      recv_byte(1'b0, rb);
      chk("R9 released after nack", {24'd0, rb}, 32'hFF);
      chk("R9 no further load", rd_cnt - r0, 3);
      bus_stop();
    end

    // R6: read without command keeps last pointer (3)
    bus_start();
    send_byte({own, 1'b1}, 1'b0, ak);
    recv_byte(1'b0, rb);
    bus_stop();
    chk("R6 pointer kept across transfers", {24'd0, rb}, {24'd0, model[3]});

    // R10: address mismatch ignored until next start
    w0 = wr_cnt;
    bus_start();
    send_byte({7'h1C, 1'b0}, 1'b0, ak);
    chk("R10 no ack on mismatch", {31'd0, ak}, 0);
    send_byte(8'h01, 1'b0, ak);
    chk("R10 command ignored", {31'd0, ak}, 0);
    send_byte(8'h77, 1'b0, ak);
    chk("R10 data ignored", wr_cnt - w0, 0);
    chk("R10 pointer kept", {30'd0, reg_sel}, 3);
    bus_start();
    send_byte({own, 1'b0}, 1'b0, ak);
    chk("R10 matching after repeated start", {31'd0, ak}, 1);
    send_byte(8'h02, 1'b0, ak);
    chk("R10 command taken again", {30'd0, reg_sel}, 2);
    bus_stop();

    // R12: one-clock spike while SCL high
    w0 = wr_cnt;
    bus_start();
    send_byte({own, 1'b0}, 1'b0, ak);
    send_byte(8'h03, 1'b0, ak);
    send_byte(8'hFF, 1'b1, ak);
    chk("R12 spike ignored ack", {31'd0, ak}, 1);
    chk("R12 spike ignored data", {24'd0, last_wd}, 32'hFF);
    chk("R12 spike ignored beat", wr_cnt - w0, 1);
    model[3] = 8'hFF;
    bus_stop();

    // R11: reset mid-transfer
    bus_start();
    send_byte({own, 1'b0}, 1'b0, ak);
    send_byte(8'h01, 1'b0, ak);
    sda_m = 1'b1; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    rst_n = 1'b0; waitq(3);
    chk("R11 pointer cleared", {30'd0, reg_sel}, 0);
    chk("R11 sda released", {31'd0, sda_oe}, 0);
    rst_n = 1'b1; waitq(2*Q);
    bus_start();
    send_byte({own, 1'b1}, 1'b0, ak);
    recv_byte(1'b0, rb);
    bus_stop();
    chk("R11 default pointer reads input", {24'd0, rb}, {24'd0, model[0]});

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule